// File: doc/BRIEF.md
# SIMT Divergent Branch Splitter

This block resolves one branch instruction for one instruction stream of a SIMT lane group. It takes the stream's program counter, its membership mask (one bit per lane), a per-lane branch condition, the branch immediate, a branch-kind flag and a per-lane computed target vector. From these it forms at most two new streams, each a (PC, mask) pair with a valid bit, and a replay indication.

A relative conditional branch splits the members into a taken group and a fall-through group. An indirect branch may have as many distinct targets as there are lanes. Only the lanes that agree with a leader lane are moved: the leader is the lowest-numbered member. All other members stay at the branch PC and are flagged for replay, so each pass serialises one target. The outputs are registered and appear one clock after the inputs are presented.

Top module: `simt_branch_split`

## Requirements
- R1: For a relative branch (kind flag 0), stream 0 carries PC = branch PC + immediate (modulo 2^32) and mask = condition AND membership.
- R2: For a relative branch, stream 1 carries PC = branch PC + 4 and mask = (NOT condition) AND membership.
- R3: Each stream's valid bit is 1 exactly when its mask has at least one bit set.
- R4: For an indirect branch (kind flag 1), the leader is the lowest-numbered lane whose membership bit is 1. Stream 0 carries the leader's target with bit 0 cleared. Its mask holds every member lane whose target, with bit 0 cleared, equals the leader's. Lane i's target occupies bits [32*i+31 : 32*i] of the target vector.
- R5: For an indirect branch, stream 1 carries the unchanged branch PC and the member lanes not in stream 0. Replay is 1 exactly when that mask is non-empty.
- R6: Replay is never asserted for a relative branch. With an all-zero membership mask, both streams are invalid and replay is 0, whatever the branch kind.
- R7: All outputs are registered: results for inputs sampled at a rising edge appear after that edge. While reset (active low) is held, every output is 0.
- R8: The two stream masks never overlap, and together they equal the membership mask. No branch yields more than two streams, whatever the number of distinct targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_pc | input | 32 | Program counter of the branch for this stream |
| br_member | input | LANES | Membership mask of the stream |
| br_cond | input | LANES | Per-lane condition for relative branches |
| br_imm | input | 32 | Branch immediate (sign-extended) |
| br_indirect | input | 1 | 0 = relative conditional, 1 = indirect |
| br_targets | input | 32*LANES | Per-lane indirect targets, lane 0 in the low bits |
| out0_valid | output | 1 | Stream 0 valid |
| out0_pc | output | 32 | Stream 0 PC |
| out0_mask | output | LANES | Stream 0 mask |
| out1_valid | output | 1 | Stream 1 valid |
| out1_pc | output | 32 | Stream 1 PC |
| out1_mask | output | LANES | Stream 1 mask |
| out_replay | output | 1 | Stream 1 must re-execute the branch |

## Verification
Every result is due exactly one rising edge after its inputs. The bench drives each vector on a falling edge and compares on the next falling edge, half a period after the registering edge. The vector walk covers both branch kinds, a leader in a non-zero lane, targets that differ only in bit 0, four distinct targets and empty masks. PCs are compared only where the stream is expected valid. Reset checks sample the outputs while reset is held, after a cycle that held live inputs.

// File: rtl/simt_branch_pkg.sv
package simt_branch_pkg;

    typedef enum logic {
        KIND_RELATIVE = 1'b0,
        KIND_INDIRECT = 1'b1
    } br_kind_e;

endpackage

// File: rtl/simt_leader_pick.sv
module simt_leader_pick #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] member,
    output logic [IDX_W-1:0] leader_idx,
    output logic             leader_found
);

    // Lowest set bit wins: scan from the top so the lowest index overwrites last.
    always_comb begin
        leader_idx   = '0;
        leader_found = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (member[i]) begin
                leader_idx   = IDX_W'(i);
                leader_found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/simt_target_match.sv
module simt_target_match #(
    parameter int LANES = 4,
    parameter int PC_W  = 32,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [PC_W*LANES-1:0] targets,
    input  logic [LANES-1:0]      member,
    input  logic [IDX_W-1:0]      leader_idx,
    output logic [PC_W-1:0]       leader_tgt,
    output logic [LANES-1:0]      agree
);

    localparam logic [PC_W-1:0] ALIGN = {{(PC_W-1){1'b1}}, 1'b0};

    logic [PC_W-1:0] lane_tgt [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_tgt[g] = targets[g*PC_W +: PC_W] & ALIGN;
    end

    assign leader_tgt = lane_tgt[leader_idx];

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign agree[g] = member[g] && (lane_tgt[g] == leader_tgt);
    end

endmodule

// File: rtl/simt_branch_split.sv
module simt_branch_split
    import simt_branch_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 32,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W-1:0]       br_pc,
    input  logic [LANES-1:0]      br_member,
    input  logic [LANES-1:0]      br_cond,
    input  logic [PC_W-1:0]       br_imm,
    input  logic                  br_indirect,
    input  logic [PC_W*LANES-1:0] br_targets,
    output logic                  out0_valid,
    output logic [PC_W-1:0]       out0_pc,
    output logic [LANES-1:0]      out0_mask,
    output logic                  out1_valid,
    output logic [PC_W-1:0]       out1_pc,
    output logic [LANES-1:0]      out1_mask,
    output logic                  out_replay
);

    typedef struct packed {
        logic             v0;
        logic [PC_W-1:0]  pc0;
        logic [LANES-1:0] m0;
        logic             v1;
        logic [PC_W-1:0]  pc1;
        logic [LANES-1:0] m1;
        logic             rp;
    } split_t;

    split_t st_d, st_q;
    logic   primed_d, primed_q;

    logic [IDX_W-1:0] lead_idx;
    logic             lead_found;
    logic [PC_W-1:0]  lead_tgt;
    logic [LANES-1:0] agree;
    br_kind_e         kind;

    assign kind = br_kind_e'(br_indirect);

    simt_leader_pick #(.LANES(LANES)) u_leader (
        .member       (br_member),
        .leader_idx   (lead_idx),
        .leader_found (lead_found)
    );

    simt_target_match #(.LANES(LANES), .PC_W(PC_W)) u_match (
        .targets    (br_targets),
        .member     (br_member),
        .leader_idx (lead_idx),
        .leader_tgt (lead_tgt),
        .agree      (agree)
    );

    always_comb begin
        st_d     = '0;
        primed_d = 1'b1;
        if (kind == KIND_RELATIVE) begin
            st_d.pc0 = br_pc + br_imm;
            st_d.m0  = br_cond & br_member;
            st_d.pc1 = br_pc + PC_W'(4);
            st_d.m1  = ~br_cond & br_member;
            st_d.rp  = 1'b0;
        end else begin
            st_d.pc0 = lead_tgt;
            st_d.m0  = lead_found ? agree : '0;
            st_d.pc1 = br_pc;
            st_d.m1  = br_member & ~st_d.m0;
            st_d.rp  = |st_d.m1;
        end
        st_d.v0 = |st_d.m0;
        st_d.v1 = |st_d.m1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            primed_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            primed_q <= primed_d;
        end
    end

    assign out0_valid = st_q.v0;
    assign out0_pc    = st_q.pc0;
    assign out0_mask  = st_q.m0;
    assign out1_valid = st_q.v1;
    assign out1_pc    = st_q.pc1;
    assign out1_mask  = st_q.m1;
    assign out_replay = st_q.rp;

    // The two streams split the members with no lane lost or doubled.
    assert_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ((out0_mask & out1_mask) == '0));

    assert_cover_members_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ((out0_mask | out1_mask) == $past(br_member)));

    assert_rel_taken_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(br_indirect)) |-> (out0_pc == $past(br_pc + br_imm)));

    assert_rel_noreplay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(br_indirect)) |-> !out_replay);

    // The leader lane (lowest member) always moves with stream 0.
    assert_ind_leader_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(br_indirect) && ($past(br_member) != '0)) |->
        ((out0_mask & ($past(br_member) & (~$past(br_member) + 1'b1))) != '0));

    assert_replay_keeps_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_replay |-> (out1_valid && out1_pc == $past(br_pc) && $past(br_indirect)));

    assert_valid_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out0_valid && out0_mask == '0, out1_valid && out1_mask == '0})
        && !(out0_valid && out0_mask == '0) && !(out1_valid && out1_mask == '0));

endmodule

// File: tb/simt_branch_split_bench.sv
module simt_branch_split_bench;

    localparam int PERIOD = 10;
    localparam int NV     = 10;

    typedef struct packed {
        logic         ind;
        logic [31:0]  pc;
        logic [3:0]   m;
        logic [3:0]   c;
        logic [31:0]  imm;
        logic [127:0] tgt;
        logic         e0v;
        logic [31:0]  e0pc;
        logic [3:0]   e0m;
        logic         e1v;
        logic [31:0]  e1pc;
        logic [3:0]   e1m;
        logic         erp;
    } vec_t;

    // tgt = {lane3, lane2, lane1, lane0}
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h100, 4'b1111, 4'b0101, 32'h40, 128'h0,
          1'b1, 32'h140, 4'b0101, 1'b1, 32'h104, 4'b1010, 1'b0},
        '{1'b0, 32'h200, 4'b1111, 4'b1111, 32'hFFFF_FFF8, 128'h0,
          1'b1, 32'h1F8, 4'b1111, 1'b0, 32'h204, 4'b0000, 1'b0},
        '{1'b0, 32'h300, 4'b0110, 4'b1001, 32'h10, 128'h0,
          1'b0, 32'h310, 4'b0000, 1'b1, 32'h304, 4'b0110, 1'b0},
        '{1'b1, 32'h400, 4'b1111, 4'b0000, 32'h0,
          {32'h800, 32'h800, 32'h800, 32'h800},
          1'b1, 32'h800, 4'b1111, 1'b0, 32'h400, 4'b0000, 1'b0},
        '{1'b1, 32'h400, 4'b1111, 4'b0000, 32'h0,
          {32'hA00, 32'h900, 32'hA00, 32'h900},
          1'b1, 32'h900, 4'b0101, 1'b1, 32'h400, 4'b1010, 1'b1},
        '{1'b1, 32'h440, 4'b1100, 4'b1111, 32'h0,
          {32'hB00, 32'hB01, 32'hC00, 32'hB00},
          1'b1, 32'hB00, 4'b1100, 1'b0, 32'h440, 4'b0000, 1'b0},
        '{1'b1, 32'h480, 4'b1111, 4'b0000, 32'h0,
          {32'h40, 32'h30, 32'h20, 32'h10},
          1'b1, 32'h10, 4'b0001, 1'b1, 32'h480, 4'b1110, 1'b1},
        '{1'b1, 32'h4C0, 4'b0000, 4'b0000, 32'h0,
          {32'h40, 32'h30, 32'h20, 32'h10},
          1'b0, 32'h0, 4'b0000, 1'b0, 32'h0, 4'b0000, 1'b0},
        '{1'b0, 32'h500, 4'b0000, 4'b1111, 32'h8, 128'h0,
          1'b0, 32'h0, 4'b0000, 1'b0, 32'h0, 4'b0000, 1'b0},
        '{1'b0, 32'h500, 4'b0011, 4'b1110, 32'h20, 128'h0,
          1'b1, 32'h520, 4'b0010, 1'b1, 32'h504, 4'b0001, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [31:0]  br_pc;
    logic [3:0]   br_member;
    logic [3:0]   br_cond;
    logic [31:0]  br_imm;
    logic         br_indirect;
    logic [127:0] br_targets;
    logic         out0_valid, out1_valid, out_replay;
    logic [31:0]  out0_pc, out1_pc;
    logic [3:0]   out0_mask, out1_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    simt_branch_split #(.LANES(4), .PC_W(32)) u_simt_branch_split (
        .clk, .rst_n, .br_pc, .br_member, .br_cond, .br_imm, .br_indirect,
        .br_targets, .out0_valid, .out0_pc, .out0_mask, .out1_valid,
        .out1_pc, .out1_mask, .out_replay
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        br_indirect = v.ind;
        br_pc       = v.pc;
        br_member   = v.m;
        br_cond     = v.c;
        br_imm      = v.imm;
        br_targets  = v.tgt;
    endtask

    task automatic check_vec(input int n, input vec_t v);
        string t;
        t = $sformatf("vec%0d %s", n, v.ind ? "R4/R5" : "R1/R2");
        chk({t, " R3 v0"}, 32'(out0_valid), 32'(v.e0v));
        chk({t, " m0"}, 32'(out0_mask), 32'(v.e0m));
        if (v.e0v) chk({t, " pc0"}, out0_pc, v.e0pc);
        chk({t, " R3 v1"}, 32'(out1_valid), 32'(v.e1v));
        chk({t, " m1"}, 32'(out1_mask), 32'(v.e1m));
        if (v.e1v) chk({t, " pc1"}, out1_pc, v.e1pc);
        chk({t, " R6 replay"}, 32'(out_replay), 32'(v.erp));
        chk({t, " R8 union"}, 32'(out0_mask | out1_mask), 32'(v.m));
    endtask

    task automatic check_reset_state(input string t);
        chk({t, " R7 v0"}, 32'(out0_valid), 0);
        chk({t, " R7 m0"}, 32'(out0_mask), 0);
        chk({t, " R7 pc0"}, out0_pc, 0);
        chk({t, " R7 v1"}, 32'(out1_valid), 0);
        chk({t, " R7 pc1"}, out1_pc, 0);
        chk({t, " R7 replay"}, 32'(out_replay), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        apply(VEC[4]);
        repeat (3) @(negedge clk);
        check_reset_state("reset");
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check_vec(i, VEC[i]);
        end
        // R7: one-cycle latency, output changes only after the edge
        apply(VEC[0]);
        @(negedge clk);
        apply(VEC[6]);
        #1;
        chk("R7 hold before edge", 32'(out0_mask), 32'(4'b0101));
        @(negedge clk);
        chk("R7 after edge", 32'(out1_mask), 32'(4'b1110));
        // R7: reset mid-run clears outputs holding a replay
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("midrun reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_vec(6, VEC[6]);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule